// File: doc/BRIEF.md
# Inbound Free-List Queue Port

This block serves message frame addresses (MFAs) out of a circular free list that lives in local memory rather than in on-chip storage. The local processor fills memory slots with free MFAs and then moves a head pointer register forward to publish them. An external requester reads a single queue port. On each such read the block fetches the 32-bit word at the tail slot through a memory read master, hands it back, and steps the tail on by one word. Software never writes the tail.

The memory address of a slot joins the upper twelve bits of a base register with the word offset of the tail. The tail wraps to offset zero at the end of a power-of-two region, whose size is set by the `QUEUE_WORDS` parameter. When head and tail are equal the list is empty. A read then returns the sentinel 0xFFFF_FFFF, touches no memory and leaves the tail where it is.

Register access is a simple select/write-enable interface with a combinational read path. Register select 0 is the base register, 1 is the head pointer, 2 is the tail pointer, and 3 reads as zero. The queue port uses a held request. `qp_req_ready` rises for exactly one cycle, with `qp_rdata` valid, when the answer is ready.

Top module: `fl_queue_port`

## Requirements
- R1: After reset the base, head and tail registers read zero, and neither `qp_req_ready` nor `mem_req_valid` is asserted.
- R2: A queue-port read of a non-empty list issues one memory read at address {base[31:20], tail offset[19:2], 2'b00} and returns the memory data on `qp_rdata` while `qp_req_ready` is high.
- R3: Each queue-port read that returns a memory entry advances the tail by 4 bytes, with no register write needed.
- R4: When head equals tail, a queue-port read returns 0xFFFF_FFFF, issues no memory read and leaves the tail unchanged.
- R5: The tail offset wraps to zero after the last word of a region of `QUEUE_WORDS` words.
- R6: Reading the head register (select 1) returns base bits 31–20 in bits 31–20, the head offset in bits 19–2 and zero in bits 1–0. A write changes only bits 19–2.
- R7: Reading the tail register (select 2) uses the head register's layout. Writes to select 2 have no effect.
- R8: With `agent_mode` low, writes to selects 1 and 2 are ignored and reads of them return zero.
- R9: While a memory read is pending, `qp_req_ready` stays low and `mem_addr` holds steady until `mem_req_ready`. Only one memory read is outstanding at a time, and `qp_req_ready` is a single-cycle pulse.
- R10: The base register (select 0) stores write bits 31–20 and reads zero in bits 19–0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agent_mode | input | 1 | High when pointer register access is permitted |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | Write when high, read when low |
| cfg_addr | input | 2 | Register select: 0 base, 1 head, 2 tail |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, zero when not selected |
| qp_req_valid | input | 1 | Queue-port read request, held until ready |
| qp_req_ready | output | 1 | One-cycle completion of the queue-port read |
| qp_rdata | output | 32 | MFA or 0xFFFF_FFFF, valid with ready |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The assertions take for granted two things. First, the requester holds `qp_req_valid` high until it sees `qp_req_ready`. Second, the memory gives exactly one `mem_rsp_valid` for each accepted request, never before acceptance and never while idle. The bench meets both with a single task that plays the requester and the memory model together. That task raises `mem_req_ready` only after a chosen number of stall cycles, and sends the response one cycle after acceptance. It drops the request one cycle after the completion pulse, which is why the ready pulse always coincides with a held request.

// File: rtl/fl_pkg.sv
package fl_pkg;

    localparam int OFF_W = 18;
    localparam int BASE_W = 12;
    localparam logic [31:0] EMPTY_MFA = 32'hFFFF_FFFF;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_HEAD = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } fetch_st_e;

    typedef struct packed {
        logic [BASE_W-1:0] base_hi;
        logic [OFF_W-1:0]  head_off;
    } regs_t;

    typedef struct packed {
        fetch_st_e   st;
        logic [31:0] data;
        logic [31:0] addr;
        logic        hit;
    } fetch_t;

endpackage

// File: rtl/fl_regs.sv
module fl_regs
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              agent_mode,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [OFF_W-1:0]  tail_off,
    output logic [31:0]       cfg_rdata,
    output logic [BASE_W-1:0] base_hi,
    output logic [OFF_W-1:0]  head_off
);

    regs_t regs_d, regs_q;
    logic  wr_stb;

    assign wr_stb = cfg_en && cfg_we;

    always_comb begin
        regs_d = regs_q;
        if (wr_stb) begin
            if (cfg_addr == SEL_BASE) begin
                regs_d.base_hi = cfg_wdata[31:32-BASE_W];
            end else if (cfg_addr == SEL_HEAD && agent_mode) begin
                regs_d.head_off = cfg_wdata[OFF_W+1:2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_en && !cfg_we) begin
            case (cfg_addr)
                SEL_BASE: cfg_rdata = {regs_q.base_hi, 20'd0};
                SEL_HEAD: if (agent_mode) cfg_rdata = {regs_q.base_hi, regs_q.head_off, 2'b00};
                SEL_TAIL: if (agent_mode) cfg_rdata = {regs_q.base_hi, tail_off, 2'b00};
                default:  cfg_rdata = '0;
            endcase
        end
    end

    assign base_hi  = regs_q.base_hi;
    assign head_off = regs_q.head_off;

    // R8: pointer writes outside agent mode leave the head untouched
    a_r8_head_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !agent_mode) |=> $stable(head_off))
        else $error("head changed by a write outside agent mode");

    // R10: the base changes only through a select-0 write
    a_r10_base_only_sel0: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && cfg_addr == SEL_BASE) |=> $stable(base_hi))
        else $error("base changed without a base write");

endmodule

// File: rtl/fl_tail.sv
module fl_tail
    import fl_pkg::*;
#(
    parameter int QUEUE_WORDS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [OFF_W-1:0] tail_off
);

    localparam int IDX_W = (QUEUE_WORDS > 1) ? $clog2(QUEUE_WORDS) : 1;

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (advance) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    generate
        if (IDX_W < OFF_W) begin : g_pad
            assign tail_off = {{(OFF_W-IDX_W){1'b0}}, idx_q};
        end else begin : g_full
            assign tail_off = idx_q[OFF_W-1:0];
        end
    endgenerate

    // R4: the tail holds whenever no entry is handed out
    a_r4_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tail_off))
        else $error("tail moved without a returned entry");

endmodule

// File: rtl/fl_fetch.sv
module fl_fetch
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qp_req_valid,
    output logic              qp_req_ready,
    output logic [31:0]       qp_rdata,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [OFF_W-1:0]  head_off,
    input  logic [OFF_W-1:0]  tail_off,
    output logic              tail_advance,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);

    fetch_t cur_q, nxt_d;
    logic   list_empty;

    assign list_empty = (head_off == tail_off);

    always_comb begin
        nxt_d         = cur_q;
        qp_req_ready  = 1'b0;
        mem_req_valid = 1'b0;
        tail_advance  = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (qp_req_valid) begin
                    if (list_empty) begin
                        nxt_d.st   = ST_DONE;
                        nxt_d.data = EMPTY_MFA;
                        nxt_d.hit  = 1'b0;
                    end else begin
                        nxt_d.st   = ST_ISSUE;
                        nxt_d.addr = {base_hi, tail_off, 2'b00};
                        nxt_d.hit  = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    nxt_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    nxt_d.data = mem_rsp_data;
                    nxt_d.st   = ST_DONE;
                end
            end
            ST_DONE: begin
                qp_req_ready = 1'b1;
                tail_advance = cur_q.hit;
                nxt_d.st     = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, data: '0, addr: '0, hit: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_addr = cur_q.addr;
    assign qp_rdata = (cur_q.st == ST_DONE) ? cur_q.data : '0;

    // R9: a stalled memory request keeps its address
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)))
        else $error("memory request dropped or address changed while stalled");

    // R9: completion is a single-cycle pulse
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        qp_req_ready |=> !qp_req_ready)
        else $error("queue-port ready held for more than one cycle");

    // R9: no new memory request while the requester is being answered
    a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !qp_req_ready)
        else $error("memory request overlaps a completion");

    // R2: completion only answers a held request
    a_r2_ready_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        qp_req_ready |-> qp_req_valid)
        else $error("ready without a pending request");

endmodule

// File: rtl/fl_queue_port.sv
module fl_queue_port
    import fl_pkg::*;
#(
    parameter int QUEUE_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        agent_mode,
    input  logic        cfg_en,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        qp_req_valid,
    output logic        qp_req_ready,
    output logic [31:0] qp_rdata,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);

    logic [BASE_W-1:0] base_hi;
    logic [OFF_W-1:0]  head_off;
    logic [OFF_W-1:0]  tail_off;
    logic              tail_advance;

    fl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .agent_mode(agent_mode),
        .cfg_en    (cfg_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tail_off  (tail_off),
        .cfg_rdata (cfg_rdata),
        .base_hi   (base_hi),
        .head_off  (head_off)
    );

    fl_tail #(.QUEUE_WORDS(QUEUE_WORDS)) u_tail (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (tail_advance),
        .tail_off(tail_off)
    );

    fl_fetch u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .qp_req_valid (qp_req_valid),
        .qp_req_ready (qp_req_ready),
        .qp_rdata     (qp_rdata),
        .base_hi      (base_hi),
        .head_off     (head_off),
        .tail_off     (tail_off),
        .tail_advance (tail_advance),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_addr     (mem_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    // R4: a read of an empty list completes without touching memory
    a_r4_empty_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        (qp_req_ready && !tail_advance) |-> (qp_rdata == EMPTY_MFA))
        else $error("empty completion without the sentinel");

endmodule

// File: tb/tb_fl_queue_port.sv
`timescale 1ns/1ps
module tb_fl_queue_port;

    localparam int QW = 16;
    localparam logic [31:0] KEY = 32'h0F0F_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        agent_mode = 1'b1;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        qp_req_valid = 1'b0;
    logic        qp_req_ready;
    logic [31:0] qp_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    fl_queue_port #(.QUEUE_WORDS(QW)) dut (
        .clk(clk), .rst_n(rst_n), .agent_mode(agent_mode),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .qp_req_valid(qp_req_valid), .qp_req_ready(qp_req_ready), .qp_rdata(qp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct packed {
        logic [17:0] head_w;
        logic [3:0]  lat;
        logic [31:0] exp_addr;
        logic        empty;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{18'd2, 4'd0, 32'hABC0_0000, 1'b0},
        '{18'd2, 4'd3, 32'hABC0_0004, 1'b0},
        '{18'd2, 4'd0, 32'hFFFF_FFFF, 1'b1},
        '{18'd5, 4'd1, 32'hABC0_0008, 1'b0},
        '{18'd5, 4'd0, 32'hABC0_000C, 1'b0},
        '{18'd5, 4'd2, 32'hABC0_0010, 1'b0},
        '{18'd5, 4'd0, 32'hFFFF_FFFF, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        #1;
        d = cfg_rdata;
        cfg_en = 1'b0;
    endtask

    task automatic qp_read(input int lat, output logic [31:0] data, output logic [31:0] addr,
                           output bit fetched, output bit stall_ok);
        int  waitc = 0;
        bit  acc = 0, rsp = 0, got = 0, seen = 0;
        logic [31:0] a0 = '0;
        fetched = 0; stall_ok = 1; addr = '0; data = 'x;
        @(negedge clk);
        qp_req_valid = 1'b1;
        for (int c = 0; c < 60 && !got; c++) begin
            @(negedge clk);
            if (rsp) begin mem_rsp_valid = 1'b0; rsp = 0; end
            if (acc) begin
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = addr ^ KEY;
                rsp = 1; acc = 0;
            end
            if (qp_req_ready) begin
                data = qp_rdata;
                got = 1;
            end else if (mem_req_valid) begin
                if (!seen) begin a0 = mem_addr; seen = 1; end
                if (mem_addr !== a0) stall_ok = 0;
                if (waitc == lat) begin
                    mem_req_ready = 1'b1;
                    addr = mem_addr;
                    fetched = 1; acc = 1;
                end else begin
                    waitc++;
                end
            end
        end
        if (rsp) mem_rsp_valid = 1'b0;
        @(negedge clk);
        qp_req_valid = 1'b0;
        if (qp_req_ready) stall_ok = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd, dat, adr;
        bit fet, stok;
        int tail_m;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'd0, qp_req_ready}, 32'd0);
        chk("R1 memreq", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        cfg_read(2'd0, rd); chk("R1 base", rd, 32'd0);
        cfg_read(2'd1, rd); chk("R1 head", rd, 32'd0);
        cfg_read(2'd2, rd); chk("R1 tail", rd, 32'd0);

        // R10 base layout
        cfg_write(2'd0, 32'hFFFF_FFFF);
        cfg_read(2'd0, rd); chk("R10 base all ones", rd, 32'hFFF0_0000);
        cfg_write(2'd0, 32'hABC1_2345);
        cfg_read(2'd0, rd); chk("R10 base", rd, 32'hABC0_0000);

        // R6 head layout
        cfg_write(2'd1, 32'hFFFF_FFFF);
        cfg_read(2'd1, rd); chk("R6 head layout", rd, 32'hABCF_FFFC);

        // R8 outside agent mode
        agent_mode = 1'b0;
        cfg_write(2'd1, 32'h0000_0008);
        cfg_read(2'd1, rd); chk("R8 head reads zero", rd, 32'd0);
        cfg_read(2'd2, rd); chk("R8 tail reads zero", rd, 32'd0);
        agent_mode = 1'b1;
        cfg_read(2'd1, rd); chk("R8 head write ignored", rd, 32'hABCF_FFFC);

        // R7 tail write ignored
        cfg_write(2'd2, 32'h0000_0020);
        cfg_read(2'd2, rd); chk("R7 tail layout", rd, 32'hABC0_0000);

        // table walk: R2 R3 R4 R9
        tail_m = 0;
        foreach (VECS[i]) begin
            cfg_write(2'd1, {12'd0, VECS[i].head_w, 2'b00});
            qp_read(int'(VECS[i].lat), dat, adr, fet, stok);
            if (VECS[i].empty) begin
                chk("R4 sentinel", dat, 32'hFFFF_FFFF);
                chk("R4 no fetch", {31'd0, fet}, 32'd0);
            end else begin
                chk("R2 address", adr, VECS[i].exp_addr);
                chk("R2 data", dat, VECS[i].exp_addr ^ KEY);
                chk("R9 stall", {31'd0, stok}, 32'd1);
                tail_m++;
            end
            cfg_read(2'd2, rd);
            chk("R3 tail", rd, 32'hABC0_0000 | (tail_m << 2));
        end

        // R5 wrap
        cfg_write(2'd1, 32'd0);
        for (int k = tail_m; k < QW; k++) begin
            qp_read(k % 3, dat, adr, fet, stok);
            chk("R5 wrap run addr", adr, 32'hABC0_0000 | (k << 2));
            chk("R5 wrap run data", dat, (32'hABC0_0000 | (k << 2)) ^ KEY);
        end
        cfg_read(2'd2, rd); chk("R5 tail wrapped", rd, 32'hABC0_0000);
        qp_read(0, dat, adr, fet, stok); chk("R4 empty after wrap", dat, 32'hFFFF_FFFF);
        cfg_write(2'd1, 32'd4);
        qp_read(1, dat, adr, fet, stok); chk("R5 fetch after wrap", adr, 32'hABC0_0000);
        cfg_read(2'd2, rd); chk("R3 tail after wrap", rd, 32'hABC0_0004);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule